// File: doc/BRIEF.md
# Multi-level interrupt priority resolver

This block decides which interrupt a small CPU core takes next. It holds a latched request bit and a programmable 3-bit priority level for each maskable peripheral source. It also watches six special sources whose rank is fixed in hardware: reset, non-maskable, debug, watchdog, single-step and address-match. When the core raises `sample`, the resolver checks every eligible source in that one cycle and picks a single winner. It then registers the winner's identifier and level and gives a one-cycle `take` strobe.

A peripheral source can win only if three things hold: the global enable `gie` is high, its level is above the processor interrupt priority level (IPL), and its level is not zero. Among eligible peripherals the highest level wins, and on a tie the lowest index wins. The special sources ignore levels, the IPL and `gie`. Updates to the IPL and to the level fields reach the arbiter only after a fixed latency. That latency depends on how the update was made, so the resolver follows the pipeline timing of the core around it.

The winner is offered as a valid/ack pair. `win_valid` rises together with `take`. `win_id` and `win_lvl` stay frozen until the core raises `win_ack`. While `win_valid` is high the resolver cannot offer another winner, so every `sample` in that window is dropped. When the ack is given for a peripheral winner, that source's latched request bit is cleared.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset, `take` and `win_valid` are low. Every level field is 0, the visible IPL is 0 and no request bit is latched. A request raised after reset, with no level written, is never taken.
- R2: Peripheral source i is eligible only when all of these hold: its request bit is latched, `gie` is high and its level is strictly greater than the visible IPL. Level 0 is therefore never taken, and an IPL of 7 blocks every peripheral. A `req_set` pulse in cycle c latches the bit, and the bit can be taken from a sample in cycle c+1 onward.
- R3: Among eligible peripherals, the highest level wins. On equal levels, the lowest index wins.
- R4: The fixed order is reset, non-maskable, debug, watchdog, then any eligible peripheral, then single-step, then address-match. The special sources are taken regardless of `gie`, the IPL and the levels. `win_id` encodes reset as 0, non-maskable as 1, debug as 2, watchdog as 3, single-step as 4, address-match as 5 and peripheral i as 6+i. `win_lvl` is 0 for a special winner.
- R5: An IPL written through the return path (`ipl_rti_we` in cycle t) is used by samples from cycle t+2 onward. A sample in cycle t+1 still uses the old IPL.
- R6: An IPL written through the direct-load path (`ipl_ctl_we` in cycle t) is used by samples from cycle t+3 onward. A sample in cycle t+2 still uses the old IPL.
- R7: A level write (`lvl_we` in cycle t) is used by samples from cycle t+2 onward. A sample in cycle t+1 still uses the old level.
- R8: `win_ack` while `win_valid` is high clears only the winning peripheral's request bit. If `req_set` hits that same bit in the same cycle, the bit stays latched. `win_ack` while `win_valid` is low has no effect.
- R9: A sample in cycle c that finds a winner while `win_valid` is low raises `take` for cycle c+1 only. `win_valid`, `win_id` and `win_lvl` then hold until the ack cycle, and `win_valid` is low from the cycle after the ack. A sample while `win_valid` is high, or one with no eligible source, produces no `take`.
- R10: The enable flag, the request bits, the level fields and the IPL are separate state. Writing one of them leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gie | input | 1 | Global enable for the peripheral sources |
| spc_rst | input | 1 | Reset-class special request |
| spc_nmi | input | 1 | Non-maskable special request |
| spc_dbg | input | 1 | Debug special request |
| spc_wdt | input | 1 | Watchdog special request |
| spc_step | input | 1 | Single-step special request |
| spc_amatch | input | 1 | Address-match special request |
| req_set | input | NSRC | Per-peripheral request pulses, latched |
| lvl_we | input | 1 | Level field write strobe |
| lvl_idx | input | $clog2(NSRC) | Level field index |
| lvl_wdata | input | LVL_W | New level value |
| ipl_rti_we | input | 1 | IPL update through the return path |
| ipl_ctl_we | input | 1 | IPL update through the direct-load path |
| ipl_wdata | input | LVL_W | New IPL value |
| sample | input | 1 | Sampling point |
| take | output | 1 | One-cycle strobe: a winner was accepted |
| win_valid | output | 1 | Winner offered and not yet acknowledged |
| win_id | output | $clog2(NSRC+6) | Winning source identifier |
| win_lvl | output | LVL_W | Winning level, 0 for a special source |
| win_ack | input | 1 | Consumes the offered winner |

## Verification
The assertions assume the following about the inputs. `lvl_idx` is always below NSRC. Two IPL updates never land in the arbiter in the same cycle; for the direct-load latency check, this means no return-path update follows a direct load by one cycle. The random stimulus keeps at least four cycles between IPL updates, and it draws level indices modulo NSRC. The bench drives `win_ack` freely, including while nothing is offered, because the design must ignore it then.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NSPC = 6;
  typedef enum int unsigned {
    SPC_RST    = 0,
    SPC_NMI    = 1,
    SPC_DBG    = 2,
    SPC_WDT    = 3,
    SPC_STEP   = 4,
    SPC_AMATCH = 5
  } spc_e;
  localparam int PERIPH_BASE = NSPC;
endpackage

// File: rtl/irq_ipl_delay.sv
module irq_ipl_delay #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rti_we,
  input  logic             ctl_we,
  input  logic [LVL_W-1:0] wdata,
  output logic [LVL_W-1:0] ipl_eff
);
  logic             a_v, b_v;
  logic [LVL_W-1:0] a_d, b_d;

  // direct loads take one extra stage; the return path joins at stage b
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_v     <= 1'b0;
      a_d     <= '0;
      b_v     <= 1'b0;
      b_d     <= '0;
      ipl_eff <= '0;
    end else begin
      a_v <= ctl_we;
      a_d <= wdata;
      if (rti_we) begin
        b_v <= 1'b1;
        b_d <= wdata;
      end else begin
        b_v <= a_v;
        b_d <= a_d;
      end
      if (b_v) ipl_eff <= b_d;
    end
  end

  p_rti_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rti_we |=> ##1 (ipl_eff == $past(wdata, 2)));

  p_ctl_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we ##1 !rti_we |=> ##1 (ipl_eff == $past(wdata, 3)));
endmodule

// File: rtl/irq_lvl_table.sv
module irq_lvl_table #(
  parameter int NSRC  = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [IDX_W-1:0]            idx,
  input  logic [LVL_W-1:0]            wdata,
  output logic [NSRC-1:0][LVL_W-1:0]  lvl
);
  logic             p_v;
  logic [IDX_W-1:0] p_idx;
  logic [LVL_W-1:0] p_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_v   <= 1'b0;
      p_idx <= '0;
      p_d   <= '0;
    end else begin
      p_v   <= we;
      p_idx <= idx;
      p_d   <= wdata;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                             lvl[i] <= '0;
      else if (p_v && (p_idx == IDX_W'(i)))   lvl[i] <= p_d;
    end

    p_lvl_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && (idx == IDX_W'(i))) |=> ##1 $stable(lvl[i]));
  end

  p_lvl_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ##1 (lvl[$past(idx, 2)] == $past(wdata, 2)));
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int NSRC = 8,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  set,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [NSRC-1:0]  req
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                                    req[i] <= 1'b0;
      else if (set[i])                               req[i] <= 1'b1;
      else if (clr_en && (clr_idx == IDX_W'(i)))     req[i] <= 1'b0;
    end

    p_set_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> req[i]);

    p_clr_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && (clr_idx == IDX_W'(i)) && !set[i]) |=> !req[i]);
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = $clog2(NSRC),
  localparam int ID_W  = $clog2(NSRC + NSPC)
) (
  input  logic [NSRC-1:0]             req,
  input  logic [NSRC-1:0][LVL_W-1:0]  lvl,
  input  logic [LVL_W-1:0]            ipl,
  input  logic                        gie,
  input  logic [NSPC-1:0]             spc,
  output logic                        found,
  output logic [ID_W-1:0]             id,
  output logic [LVL_W-1:0]            lvl_out
);
  localparam logic [ID_W-1:0] ID_BASE = ID_W'(PERIPH_BASE);

  logic [NSRC-1:0]  elig;
  logic             m_found;
  logic [IDX_W-1:0] m_idx;
  logic [LVL_W-1:0] m_lvl;

  for (genvar i = 0; i < NSRC; i++) begin : g_elig
    assign elig[i] = gie && req[i] && (lvl[i] > ipl);
  end

  // descending scan with >= leaves the lowest index on equal levels
  always_comb begin
    m_found = 1'b0;
    m_idx   = '0;
    m_lvl   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && (!m_found || (lvl[i] >= m_lvl))) begin
        m_found = 1'b1;
        m_idx   = IDX_W'(i);
        m_lvl   = lvl[i];
      end
    end
  end

  always_comb begin
    found   = 1'b1;
    lvl_out = '0;
    id      = '0;
    if      (spc[SPC_RST])    id = ID_W'(SPC_RST);
    else if (spc[SPC_NMI])    id = ID_W'(SPC_NMI);
    else if (spc[SPC_DBG])    id = ID_W'(SPC_DBG);
    else if (spc[SPC_WDT])    id = ID_W'(SPC_WDT);
    else if (m_found) begin
      id      = ID_BASE + ID_W'(m_idx);
      lvl_out = m_lvl;
    end
    else if (spc[SPC_STEP])   id = ID_W'(SPC_STEP);
    else if (spc[SPC_AMATCH]) id = ID_W'(SPC_AMATCH);
    else                      found = 1'b0;
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = $clog2(NSRC),
  localparam int ID_W  = $clog2(NSRC + NSPC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gie,
  input  logic              spc_rst,
  input  logic              spc_nmi,
  input  logic              spc_dbg,
  input  logic              spc_wdt,
  input  logic              spc_step,
  input  logic              spc_amatch,
  input  logic [NSRC-1:0]   req_set,
  input  logic              lvl_we,
  input  logic [IDX_W-1:0]  lvl_idx,
  input  logic [LVL_W-1:0]  lvl_wdata,
  input  logic              ipl_rti_we,
  input  logic              ipl_ctl_we,
  input  logic [LVL_W-1:0]  ipl_wdata,
  input  logic              sample,
  output logic              take,
  output logic              win_valid,
  output logic [ID_W-1:0]   win_id,
  output logic [LVL_W-1:0]  win_lvl,
  input  logic              win_ack
);
  localparam logic [ID_W-1:0] ID_BASE = ID_W'(PERIPH_BASE);

  logic [LVL_W-1:0]           ipl_eff;
  logic [NSRC-1:0][LVL_W-1:0] lvl;
  logic [NSRC-1:0]            req;
  logic [NSPC-1:0]            spc;
  logic                       found;
  logic [ID_W-1:0]            pick_id;
  logic [LVL_W-1:0]           pick_lvl;
  logic                       accept;
  logic                       clr_en;
  logic [IDX_W-1:0]           clr_idx;

  assign spc = {spc_amatch, spc_step, spc_wdt, spc_dbg, spc_nmi, spc_rst};

  irq_ipl_delay #(.LVL_W(LVL_W)) u_ipl (
    .clk(clk), .rst_n(rst_n), .rti_we(ipl_rti_we), .ctl_we(ipl_ctl_we),
    .wdata(ipl_wdata), .ipl_eff(ipl_eff));

  irq_lvl_table #(.NSRC(NSRC), .LVL_W(LVL_W)) u_lvl (
    .clk(clk), .rst_n(rst_n), .we(lvl_we), .idx(lvl_idx),
    .wdata(lvl_wdata), .lvl(lvl));

  irq_req_latch #(.NSRC(NSRC)) u_req (
    .clk(clk), .rst_n(rst_n), .set(req_set), .clr_en(clr_en),
    .clr_idx(clr_idx), .req(req));

  irq_pick #(.NSRC(NSRC), .LVL_W(LVL_W)) u_pick (
    .req(req), .lvl(lvl), .ipl(ipl_eff), .gie(gie), .spc(spc),
    .found(found), .id(pick_id), .lvl_out(pick_lvl));

  assign accept  = sample && !win_valid && found;
  assign clr_en  = win_ack && win_valid && (win_id >= ID_BASE);
  assign clr_idx = IDX_W'(win_id - ID_BASE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take      <= 1'b0;
      win_valid <= 1'b0;
      win_id    <= '0;
      win_lvl   <= '0;
    end else begin
      take <= accept;
      if (accept) begin
        win_valid <= 1'b1;
        win_id    <= pick_id;
        win_lvl   <= pick_lvl;
      end else if (win_ack && win_valid) begin
        win_valid <= 1'b0;
      end
    end
  end

  p_take_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

  p_take_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> win_valid);

  p_hold_until_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !win_ack) |=> (win_valid && $stable(win_id) && $stable(win_lvl)));

  p_mask_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (win_id >= ID_BASE)) |-> ((win_lvl > $past(ipl_eff)) && $past(gie)));

  p_reset_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !win_valid && spc_rst) |=> (take && (win_id == '0)));

  p_special_lvl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (win_id < ID_BASE)) |-> (win_lvl == '0));
endmodule

// File: tb/tb_irq_prio_arb.sv
module tb_irq_prio_arb;
  localparam int NSRC  = 8;
  localparam int LVL_W = 3;
  localparam int IDX_W = $clog2(NSRC);
  localparam int ID_W  = $clog2(NSRC + 6);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d_gie, d_rst, d_nmi, d_dbg, d_wdt, d_step, d_am;
  logic [NSRC-1:0]  d_req;
  logic             d_lvl_we, d_rti, d_ctl, d_sample, d_ack;
  logic [IDX_W-1:0] d_lvl_idx;
  logic [LVL_W-1:0] d_lvl_wd, d_ipl_wd;
  logic             take, win_valid;
  logic [ID_W-1:0]  win_id;
  logic [LVL_W-1:0] win_lvl;

  always #4 clk = ~clk;

  irq_prio_arb #(.NSRC(NSRC), .LVL_W(LVL_W)) dut (
    .clk(clk), .rst_n(rst_n), .gie(d_gie), .spc_rst(d_rst), .spc_nmi(d_nmi),
    .spc_dbg(d_dbg), .spc_wdt(d_wdt), .spc_step(d_step), .spc_amatch(d_am),
    .req_set(d_req), .lvl_we(d_lvl_we), .lvl_idx(d_lvl_idx), .lvl_wdata(d_lvl_wd),
    .ipl_rti_we(d_rti), .ipl_ctl_we(d_ctl), .ipl_wdata(d_ipl_wd), .sample(d_sample),
    .take(take), .win_valid(win_valid), .win_id(win_id), .win_lvl(win_lvl),
    .win_ack(d_ack));

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  string tag = "R1";
  int m_lvl[NSRC];
  logic [NSRC-1:0] m_req;
  int m_ipl, m_id, m_wl;
  bit m_valid, e_take;
  int lv_due[4], lv_i[4], lv_d[4], ip_due[4], ip_d[4];

  function automatic void pick(output bit f, output int id, output int wl);
    int bi = -1, bl = 0;
    for (int i = 0; i < NSRC; i++)
      if (m_req[i] && d_gie && m_lvl[i] > m_ipl && m_lvl[i] > bl) begin bi = i; bl = m_lvl[i]; end
    f = 1; wl = 0;
    if (d_rst) id = 0; else if (d_nmi) id = 1; else if (d_dbg) id = 2;
    else if (d_wdt) id = 3; else if (bi >= 0) begin id = 6 + bi; wl = bl; end
    else if (d_step) id = 4; else if (d_am) id = 5; else begin f = 0; id = 0; end
  endfunction

  task automatic chk(string rq, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual %0d expected %0d", rq, what, cyc, act, exp);
    end
  endtask

  task automatic idle();
    d_gie = 1; d_rst = 0; d_nmi = 0; d_dbg = 0; d_wdt = 0; d_step = 0; d_am = 0;
    d_req = '0; d_lvl_we = 0; d_lvl_idx = '0; d_lvl_wd = '0;
    d_rti = 0; d_ctl = 0; d_ipl_wd = '0; d_sample = 0; d_ack = 0;
  endtask

  task automatic step();
    bit f; int id, wl, s;
    for (int k = 0; k < 4; k++) begin
      if (lv_due[k] == cyc) begin m_lvl[lv_i[k]] = lv_d[k]; lv_due[k] = -1; end
      if (ip_due[k] == cyc) begin m_ipl = ip_d[k]; ip_due[k] = -1; end
    end
    pick(f, id, wl);
    e_take = d_sample && !m_valid && f;
    if (d_lvl_we) begin s = (cyc + 2) % 4; lv_due[s] = cyc + 2; lv_i[s] = int'(d_lvl_idx); lv_d[s] = int'(d_lvl_wd); end
    if (d_ctl) begin s = (cyc + 3) % 4; ip_due[s] = cyc + 3; ip_d[s] = int'(d_ipl_wd); end
    if (d_rti) begin s = (cyc + 2) % 4; ip_due[s] = cyc + 2; ip_d[s] = int'(d_ipl_wd); end
    if (e_take) begin m_valid = 1; m_id = id; m_wl = wl; end
    else if (d_ack && m_valid) begin
      m_valid = 0;
      if (m_id >= 6) m_req[m_id - 6] = 1'b0;
    end
    m_req = m_req | d_req;
    @(negedge clk);
    chk(tag == "" ? "R9" : tag, int'(take), int'(e_take), "take");
    chk(tag == "" ? "R9" : tag, int'(win_valid), int'(m_valid), "win_valid");
    if (m_valid) begin
      chk(tag == "" ? (m_id < 6 ? "R4" : "R3") : tag, int'(win_id), m_id, "win_id");
      chk(tag == "" ? "R3" : tag, int'(win_lvl), m_wl, "win_lvl");
    end
    cyc++;
    idle();
  endtask

  task automatic setlvl(int i, int v);
    d_lvl_we = 1; d_lvl_idx = IDX_W'(i); d_lvl_wd = LVL_W'(v); step(); step(); step();
  endtask

  task automatic ackit();
    d_ack = 1; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cool = 0;
    void'($urandom(32'h5eed_1a7e));
    idle();
    for (int k = 0; k < 4; k++) begin lv_due[k] = -1; ip_due[k] = -1; end
    for (int i = 0; i < NSRC; i++) m_lvl[i] = 0;
    m_req = '0; m_ipl = 0; m_valid = 0; m_id = 0; m_wl = 0;
    repeat (3) @(negedge clk);
    chk("R1", int'(take), 0, "take in reset");
    chk("R1", int'(win_valid), 0, "valid in reset");
    rst_n = 1'b1;
    // R1: requests with level 0 never win
    tag = "R1"; step();
    d_req = '1; step();
    d_sample = 1; step(); step();
    // R7: level write visible two cycles later
    tag = "R7";
    d_lvl_we = 1; d_lvl_idx = 2; d_lvl_wd = 3; step();
    d_sample = 1; step();
    d_sample = 1; step();
    ackit();
    // R8: ack while idle ignored; set during clearing ack keeps bit
    tag = "R8";
    d_ack = 1; step();
    d_sample = 1; step(); step();
    d_ack = 1; d_req = 8'h04; step();
    d_sample = 1; step(); ackit();
    // R5: return-path IPL at t+2
    tag = "R5";
    d_req = 8'h04; d_rti = 1; d_ipl_wd = 3; step();
    d_sample = 1; step();
    d_ack = 1; d_req = 8'h04; step();
    d_sample = 1; step(); step(); step();
    // R6: direct-load IPL at t+3
    tag = "R6";
    d_ctl = 1; d_ipl_wd = 2; step();
    step();
    d_sample = 1; step();
    d_sample = 1; step(); ackit();
    // R3: highest level, tie broken by low index
    tag = "R3";
    d_rti = 1; d_ipl_wd = 0; step(); step(); step(); step();
    setlvl(1, 5); setlvl(4, 5); setlvl(6, 4);
    d_req = 8'h52; step();
    d_sample = 1; step(); ackit();
    d_sample = 1; step(); ackit();
    d_sample = 1; step(); ackit();
    // R2: gie low and IPL 7 mask peripherals
    tag = "R2";
    d_req = 8'h10; step();
    d_gie = 0; d_sample = 1; step(); step();
    d_rti = 1; d_ipl_wd = 7; step(); step(); step(); step();
    d_sample = 1; step(); step();
    // R4: specials bypass mask and follow fixed order
    tag = "R4";
    d_gie = 0; d_step = 1; d_am = 1; d_sample = 1; step(); ackit();
    d_nmi = 1; d_dbg = 1; d_sample = 1; step(); ackit();
    d_rst = 1; d_nmi = 1; d_sample = 1; step(); ackit();
    d_rti = 1; d_ipl_wd = 0; step(); step(); step(); step();
    d_wdt = 1; d_step = 1; d_sample = 1; step(); ackit();
    d_step = 1; d_am = 1; d_sample = 1; step(); ackit();
    // R10: random mix of all writes checked against the model
    tag = "";
    for (int n = 0; n < 6000; n++) begin
      d_req = NSRC'($urandom & $urandom & $urandom);
      d_lvl_we = ($urandom % 4 == 0);
      d_lvl_idx = IDX_W'($urandom % NSRC);
      d_lvl_wd = LVL_W'($urandom);
      if (cool == 0 && ($urandom % 8 == 0)) begin
        if ($urandom % 2 == 0) d_rti = 1; else d_ctl = 1;
        d_ipl_wd = LVL_W'($urandom % 6);
        cool = 4;
      end else if (cool > 0) cool--;
      d_gie = ($urandom % 8 != 0);
      d_rst = ($urandom % 60 == 0); d_nmi = ($urandom % 50 == 0);
      d_dbg = ($urandom % 50 == 0); d_wdt = ($urandom % 50 == 0);
      d_step = ($urandom % 30 == 0); d_am = ($urandom % 30 == 0);
      d_sample = ($urandom % 3 == 0);
      d_ack = ($urandom % 3 == 0);
      step();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule